// File: doc/BRIEF.md
# SD Block-Transfer Descriptor Queue

This block sits between software and the block data engine of an SD host controller. It keeps two descriptor queues, one for writes to the card (transmit) and one for reads from the card (receive). Software posts a descriptor by writing two 32-bit words to the port of one direction. The first word is the memory buffer address and the second is the card block address. The block stores the card address without change, so software supplies a sector number for high-capacity cards and a byte address (sector times 512) for standard-capacity cards.

Software can read how many free slots each direction has. A slot stays occupied from the moment its descriptor is posted until its transfer reports back. The block hands descriptors to the downstream transfer engine one at a time over a valid/ready handshake. It then waits for a done pulse that carries an error code. Each result is folded into a sticky data status register, which software clears by writing zero. When both queues hold work, dispatch alternates between the two directions.

Top module: `sd_bd_queue`

## Requirements
- R1: After reset, both free counts read DEPTH (4 by default). The free-count word at offset 0x50 therefore reads 0x0000_0404, the data status word at offset 0x54 reads 0, and `xfer_valid` is low.
- R2: A descriptor is two consecutive writes to one port: offset 0x80 for transmit and offset 0x60 for receive. The first word is the memory address and the second word is the card address. Both appear unchanged on `xfer_mem_addr` / `xfer_card_addr`, with `xfer_dir` = 0 for transmit and 1 for receive.
- R3: The word at offset 0x50 holds the transmit free count in bits 7:0 and the receive free count in bits 15:8. A direction's count drops by one in the cycle its second descriptor word is written.
- R4: While a direction's free count is 0, any write to its port is ignored: no word is latched and no descriptor is queued. The same write sets bit 8 of the data status register, which then stays set.
- R5: Each port has its own half-descriptor latch. A write to the other direction's port, including a complete descriptor, leaves a pending first word untouched.
- R6: When both queues hold descriptors, successive dispatches alternate between transmit and receive.
- R7: Only one transfer is outstanding at a time. After a handshake, `xfer_valid` stays low until the matching done pulse has been taken.
- R8: Once raised, `xfer_valid` and the descriptor fields hold steady until `xfer_ready` is seen high.
- R9: A done pulse ORs a result into the data status register. An error code of 0 sets bit 0. Error code bits 0, 1, 2 and 3 set status bits 1 (retry), 2 (FIFO), 4 (command) and 5 (line transmission). In the same cycle, the free count of the transfer's direction rises by one.
- R10: The data status register reads 0 until a transfer finishes or an overflow occurs. Writing 0 to offset 0x54 clears it, and writing any nonzero value has no effect.
- R11: A done pulse is ignored when no transfer has been handed over. This covers both the case of no outstanding transfer and the case of a descriptor still waiting for `xfer_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 8 | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| xfer_valid | output | 1 | Descriptor offered to the transfer engine |
| xfer_ready | input | 1 | Transfer engine accepts the descriptor |
| xfer_dir | output | 1 | 0 transmit, 1 receive |
| xfer_mem_addr | output | 32 | Memory buffer address of the offered descriptor |
| xfer_card_addr | output | 32 | Card block address of the offered descriptor |
| done_valid | input | 1 | Transfer engine reports the end of the outstanding transfer |
| done_err | input | 4 | Error code with the done pulse, 0 for success |

## Verification
A second descriptor word written at edge N is counted in the free word at once, because reads are combinational. The descriptor appears on `xfer_valid` after edge N+1 if the dispatcher is idle. A done pulse sampled at an edge updates the status word and the free count together after that edge. The bench drives every input on the falling edge and reads the combinational outputs 1 ns later. Each expected value is therefore taken in the half cycle after the edge that is due to produce it. Where the exact launch cycle is not part of a requirement, the bench polls `xfer_valid` at falling edges with a bound instead of assuming a fixed cycle.

// File: rtl/sd_bdq_pkg.sv
package sd_bdq_pkg;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 32;
  localparam int STAT_W = 9;
  localparam int ERR_W  = 4;

  // Register byte offsets (software decodes these)
  localparam logic [ADDR_W-1:0] OFS_FREE = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_RXQ  = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_TXQ  = 8'h80;

  // Data status bit positions
  localparam int BIT_DONE  = 0;
  localparam int BIT_RETRY = 1;
  localparam int BIT_FIFO  = 2;
  localparam int BIT_CMD   = 4;
  localparam int BIT_LINE  = 5;
  localparam int BIT_OVF   = 8;

  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;

  typedef struct packed {
    logic [WORD_W-1:0] mem_addr;
    logic [WORD_W-1:0] card_addr;
  } bd_t;

  // Map an engine error code onto data status bits
  function automatic logic [STAT_W-1:0] result_bits(input logic [ERR_W-1:0] err);
    logic [STAT_W-1:0] r;
    r            = '0;
    r[BIT_DONE]  = (err == '0);
    r[BIT_RETRY] = err[0];
    r[BIT_FIFO]  = err[1];
    r[BIT_CMD]   = err[2];
    r[BIT_LINE]  = err[3];
    return r;
  endfunction

  // Alternate when both directions have work
  function automatic dir_e pick_next(input logic tx_ne, input logic rx_ne, input dir_e last);
    if (tx_ne && rx_ne) return (last == DIR_TX) ? DIR_RX : DIR_TX;
    return tx_ne ? DIR_TX : DIR_RX;
  endfunction
endpackage

// File: rtl/bdq_lane.sv
module bdq_lane
  import sd_bdq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              pop,
  input  logic              slot_release,
  output logic              not_empty,
  output bd_t               head,
  output logic [CW-1:0]     free_cnt,
  output logic              push_ev,
  output logic              ovf_ev,
  output logic              half_pending
);
  logic [WORD_W-1:0] first_q;
  logic              pend_q;
  bd_t               mem [DEPTH];
  logic [PW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     used_q, free_q;
  logic              accept;

  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign accept  = wr_hit && (free_q != '0);
  assign ovf_ev  = wr_hit && (free_q == '0);
  assign push_ev = accept && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      first_q <= '0;
    end else if (accept) begin
      pend_q <= !pend_q;
      if (!pend_q) first_q <= wr_word;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ev) mem[wp_q] <= '{mem_addr: first_q, card_addr: wr_word};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      used_q <= '0;
      free_q <= CW'(DEPTH);
    end else begin
      if (push_ev) wp_q <= ptr_step(wp_q);
      if (pop)     rp_q <= ptr_step(rp_q);
      case ({push_ev, pop})
        2'b10:   used_q <= used_q + 1'b1;
        2'b01:   used_q <= used_q - 1'b1;
        default: used_q <= used_q;
      endcase
      case ({push_ev, slot_release})
        2'b10:   free_q <= free_q - 1'b1;
        2'b01:   free_q <= free_q + 1'b1;
        default: free_q <= free_q;
      endcase
    end
  end

  assign not_empty    = (used_q != '0);
  assign head         = mem[rp_q];
  assign free_cnt     = free_q;
  assign half_pending = pend_q;
endmodule

// File: rtl/bdq_dispatch.sv
module bdq_dispatch
  import sd_bdq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_ne,
  input  logic rx_ne,
  input  bd_t  tx_head,
  input  bd_t  rx_head,
  input  logic xfer_ready,
  input  logic done_valid,
  output logic tx_pop,
  output logic rx_pop,
  output logic xfer_valid,
  output dir_e xfer_dir,
  output bd_t  xfer_bd,
  output logic busy,
  output logic done_fire,
  output dir_e done_dir
);
  dir_e last_q, dir_q, pick;
  logic busy_q, valid_q, launch;
  bd_t  bd_q;

  assign pick      = pick_next(tx_ne, rx_ne, last_q);
  assign launch    = !busy_q && (tx_ne || rx_ne);
  assign tx_pop    = launch && (pick == DIR_TX);
  assign rx_pop    = launch && (pick == DIR_RX);
  assign done_fire = done_valid && busy_q && !valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= DIR_RX;
      dir_q   <= DIR_TX;
      bd_q    <= '0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      valid_q <= 1'b1;
      last_q  <= pick;
      dir_q   <= pick;
      bd_q    <= (pick == DIR_TX) ? tx_head : rx_head;
    end else begin
      if (valid_q && xfer_ready) valid_q <= 1'b0;
      if (done_fire)             busy_q  <= 1'b0;
    end
  end

  assign xfer_valid = valid_q;
  assign xfer_dir   = dir_q;
  assign xfer_bd    = bd_q;
  assign busy       = busy_q;
  assign done_dir   = dir_q;
endmodule

// File: rtl/bdq_status.sv
module bdq_status
  import sd_bdq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_req,
  input  logic              done_fire,
  input  logic [ERR_W-1:0]  err,
  input  logic              ovf_any,
  output logic [STAT_W-1:0] stat
);
  logic [STAT_W-1:0] stat_q, stat_nxt;

  always_comb begin
    stat_nxt = clear_req ? '0 : stat_q;
    if (done_fire) stat_nxt = stat_nxt | result_bits(err);
    if (ovf_any)   stat_nxt[BIT_OVF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_nxt;
  end

  assign stat = stat_q;
endmodule

// File: rtl/sd_bd_queue.sv
module sd_bd_queue
  import sd_bdq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [7:0]  reg_wr_addr,
  input  logic [31:0] reg_wr_data,
  input  logic [7:0]  reg_rd_addr,
  output logic [31:0] reg_rd_data,
  output logic        xfer_valid,
  input  logic        xfer_ready,
  output logic        xfer_dir,
  output logic [31:0] xfer_mem_addr,
  output logic [31:0] xfer_card_addr,
  input  logic        done_valid,
  input  logic [3:0]  done_err
);
  localparam int NLANE = 2;  // index 0 transmit, 1 receive
  localparam logic [ADDR_W-1:0] LANE_OFS [NLANE] = '{OFS_TXQ, OFS_RXQ};

  logic [NLANE-1:0] lane_hit, lane_pop, lane_ne, lane_push, lane_ovf, lane_pend, lane_rel;
  logic [CW-1:0]    lane_free [NLANE];
  bd_t              lane_head [NLANE];

  logic              busy, done_fire, clear_req;
  dir_e              done_dir, disp_dir;
  bd_t               disp_bd;
  logic [STAT_W-1:0] data_stat;

  generate
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign lane_hit[g] = reg_wr_en && (reg_wr_addr == LANE_OFS[g]);
      assign lane_rel[g] = done_fire && (done_dir == dir_e'(g));
      bdq_lane #(.DEPTH(DEPTH)) u_lane (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_hit       (lane_hit[g]),
        .wr_word      (reg_wr_data),
        .pop          (lane_pop[g]),
        .slot_release (lane_rel[g]),
        .not_empty    (lane_ne[g]),
        .head         (lane_head[g]),
        .free_cnt     (lane_free[g]),
        .push_ev      (lane_push[g]),
        .ovf_ev       (lane_ovf[g]),
        .half_pending (lane_pend[g])
      );
    end
  endgenerate

  bdq_dispatch u_disp (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_ne      (lane_ne[0]),
    .rx_ne      (lane_ne[1]),
    .tx_head    (lane_head[0]),
    .rx_head    (lane_head[1]),
    .xfer_ready (xfer_ready),
    .done_valid (done_valid),
    .tx_pop     (lane_pop[0]),
    .rx_pop     (lane_pop[1]),
    .xfer_valid (xfer_valid),
    .xfer_dir   (disp_dir),
    .xfer_bd    (disp_bd),
    .busy       (busy),
    .done_fire  (done_fire),
    .done_dir   (done_dir)
  );

  assign clear_req = reg_wr_en && (reg_wr_addr == OFS_STAT) && (reg_wr_data == '0);

  bdq_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_req (clear_req),
    .done_fire (done_fire),
    .err       (done_err),
    .ovf_any   (|lane_ovf),
    .stat      (data_stat)
  );

  assign xfer_dir       = logic'(disp_dir);
  assign xfer_mem_addr  = disp_bd.mem_addr;
  assign xfer_card_addr = disp_bd.card_addr;

  always_comb begin
    case (reg_rd_addr)
      OFS_FREE: reg_rd_data = {16'b0, 8'(lane_free[1]), 8'(lane_free[0])};
      OFS_STAT: reg_rd_data = 32'(data_stat);
      default:  reg_rd_data = '0;
    endcase
  end
endmodule

// File: rtl/bdq_checker.sv
module bdq_checker #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_valid,
  input logic          xfer_ready,
  input logic          xfer_dir,
  input logic [31:0]   xfer_mem_addr,
  input logic [31:0]   xfer_card_addr,
  input logic          busy,
  input logic          done_fire,
  input logic          done_dir,
  input logic [CW-1:0] tx_free,
  input logic [CW-1:0] rx_free,
  input logic [1:0]    hit,
  input logic [1:0]    push,
  input logic [1:0]    ovf,
  input logic [1:0]    pend,
  input logic          clear_req,
  input logic [8:0]    stat
);
  // R8: offer held until accepted
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_mem_addr)
                                  && $stable(xfer_card_addr) && $stable(xfer_dir));

  // R7: no new offer while a transfer is outstanding
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done_fire |=> !$rose(xfer_valid));

  // R4: write into a full direction sets the overflow flag and queues nothing
  a_r4_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf[0] || ovf[1] |=> stat[8]);
  a_r4_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] && (tx_free == '0) |-> !push[0]);

  // R5: other port's traffic leaves a half descriptor alone
  a_r5_isolate: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] && !hit[0] |=> $stable(pend[0]));

  // R9: completion frees the slot and posts a result in the same cycle
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire && !done_dir && !push[0] |=> tx_free == $past(tx_free) + 1'b1);
  a_r9_result: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire |=> (stat & 9'h037) != 9'h000);

  // R10: zero write clears when nothing new arrives
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req && !done_fire && !(ovf[0] || ovf[1]) |=> stat == 9'h000);

  // R3: counts never exceed capacity
  always_comb begin
    if (rst_n) begin
      a_r3_bound: assert (tx_free <= CW'(DEPTH) && rx_free <= CW'(DEPTH));
    end
  end
endmodule

bind sd_bd_queue bdq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .xfer_valid     (xfer_valid),
  .xfer_ready     (xfer_ready),
  .xfer_dir       (xfer_dir),
  .xfer_mem_addr  (xfer_mem_addr),
  .xfer_card_addr (xfer_card_addr),
  .busy           (busy),
  .done_fire      (done_fire),
  .done_dir       (done_dir),
  .tx_free        (lane_free[0]),
  .rx_free        (lane_free[1]),
  .hit            (lane_hit),
  .push           (lane_push),
  .ovf            (lane_ovf),
  .pend           (lane_pend),
  .clear_req      (clear_req),
  .stat           (data_stat)
);

// File: tb/tb_sd_bd_queue.sv
`timescale 1ns/1ps
module tb_sd_bd_queue;
  localparam int DEPTH = 4;
  localparam logic [7:0] A_FREE = 8'h50, A_STAT = 8'h54, A_RX = 8'h60, A_TX = 8'h80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [7:0]  reg_wr_addr, reg_rd_addr;
  logic [31:0] reg_wr_data, reg_rd_data;
  logic        xfer_valid, xfer_ready, xfer_dir;
  logic [31:0] xfer_mem_addr, xfer_card_addr;
  logic        done_valid;
  logic [3:0]  done_err;

  sd_bd_queue #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_dir(xfer_dir),
    .xfer_mem_addr(xfer_mem_addr), .xfer_card_addr(xfer_card_addr),
    .done_valid(done_valid), .done_err(done_err)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct packed {
    logic        dir;
    logic [31:0] mem;
    logic [31:0] card;
    logic [3:0]  err;
    logic [8:0]  exp_stat;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 32'h1000_0000, 32'h0000_0007, 4'h0, 9'h001},
    '{1'b1, 32'h2000_0040, 32'h0000_0E00, 4'h1, 9'h002},
    '{1'b0, 32'h3000_0000, 32'hFFFF_FFFF, 4'h2, 9'h004},
    '{1'b1, 32'h4000_0100, 32'h0000_0200, 4'h4, 9'h010},
    '{1'b0, 32'h5000_0000, 32'h1234_5678, 4'h8, 9'h020},
    '{1'b1, 32'h6000_0000, 32'h0000_0000, 4'hF, 9'h036}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd_addr = a;
    #1;
    d = reg_rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en   = 1'b1;
    reg_wr_addr = a;
    reg_wr_data = d;
    @(negedge clk);
    reg_wr_en   = 1'b0;
  endtask

  task automatic put_bd(input logic [7:0] port, input logic [31:0] m, input logic [31:0] c);
    wr(port, m);
    wr(port, c);
  endtask

  task automatic wait_valid(input string tag);
    for (int w = 0; w < 60 && !xfer_valid; w++) @(negedge clk);
    check({tag, " xfer_valid raised"}, 32'(xfer_valid), 32'd1);
  endtask

  // Model of the transfer engine: accept, stay busy, report
  task automatic serve(input string tag, input logic d, input logic [31:0] m,
                       input logic [31:0] c, input logic [3:0] e, input int stall);
    wait_valid(tag);
    for (int s = 0; s < stall; s++) @(negedge clk);
    check({tag, " dir"}, 32'(xfer_dir), 32'(d));
    check({tag, " mem addr"}, xfer_mem_addr, m);
    check({tag, " card addr"}, xfer_card_addr, c);
    xfer_ready = 1'b1;
    @(negedge clk);
    xfer_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check({tag, " R7 no second offer"}, 32'(xfer_valid), 32'd0);
      @(negedge clk);
    end
    done_valid = 1'b1;
    done_err   = e;
    @(negedge clk);
    done_valid = 1'b0;
    done_err   = '0;
  endtask

  logic [31:0] v;

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0;
    reg_rd_addr = '0; xfer_ready = 1'b0; done_valid = 1'b0; done_err = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(A_FREE, v); check("R1 free word", v, 32'h0000_0404);
    rd(A_STAT, v); check("R1 status", v, 32'h0);
    check("R1 xfer_valid", 32'(xfer_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2 fields, R9 result mapping and slot return
    for (int i = 0; i < NVEC; i++) begin
      wr(A_STAT, 32'h0);
      put_bd(VEC[i].dir ? A_RX : A_TX, VEC[i].mem, VEC[i].card);
      serve("R2 table", VEC[i].dir, VEC[i].mem, VEC[i].card, VEC[i].err, 0);
      rd(A_STAT, v); check("R9 table status", v, 32'(VEC[i].exp_stat));
      rd(A_FREE, v); check("R9 table free restored", v, 32'h0000_0404);
    end

    // R10 nonzero write ignored, zero write clears
    rd(A_STAT, v); check("R10 status before write", v, 32'h036);
    wr(A_STAT, 32'h0000_1234);
    rd(A_STAT, v); check("R10 nonzero write no effect", v, 32'h036);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R10 zero write clears", v, 32'h0);

    // R3 counts and R6 alternation, R8 stall
    put_bd(A_TX, 32'hA000_0000, 32'h0000_00A1);
    put_bd(A_TX, 32'hB000_0000, 32'h0000_00B1);
    put_bd(A_RX, 32'hC000_0000, 32'h0000_00C1);
    rd(A_FREE, v); check("R3 free word after posts", v, 32'h0000_0302);
    serve("R8 stalled tx", 1'b0, 32'hA000_0000, 32'h0000_00A1, 4'h0, 3);
    serve("R6 rx second", 1'b1, 32'hC000_0000, 32'h0000_00C1, 4'h0, 0);
    serve("R6 tx third", 1'b0, 32'hB000_0000, 32'h0000_00B1, 4'h0, 0);
    rd(A_FREE, v); check("R3 free word after drain", v, 32'h0000_0404);

    // R9 status and free count change at the same edge
    wr(A_STAT, 32'h0);
    put_bd(A_TX, 32'hD000_0000, 32'h0000_00D1);
    wait_valid("R9 same edge");
    xfer_ready = 1'b1; @(negedge clk); xfer_ready = 1'b0;
    done_valid = 1'b1; done_err = 4'h0;
    rd(A_FREE, v); check("R9 free before done edge", v, 32'h0000_0403);
    rd(A_STAT, v); check("R9 status before done edge", v, 32'h0);
    @(negedge clk);
    done_valid = 1'b0;
    rd(A_FREE, v); check("R9 free after done edge", v, 32'h0000_0404);
    rd(A_STAT, v); check("R9 status after done edge", v, 32'h001);

    // R9 sticky OR across two results
    wr(A_STAT, 32'h0);
    put_bd(A_RX, 32'h1111_0000, 32'h0000_0011);
    serve("R9 sticky a", 1'b1, 32'h1111_0000, 32'h0000_0011, 4'h1, 0);
    put_bd(A_TX, 32'h2222_0000, 32'h0000_0022);
    serve("R9 sticky b", 1'b0, 32'h2222_0000, 32'h0000_0022, 4'h8, 0);
    rd(A_STAT, v); check("R9 sticky OR", v, 32'h022);

    // R4 overflow on a full transmit queue
    wr(A_STAT, 32'h0);
    for (int k = 0; k < DEPTH; k++) put_bd(A_TX, 32'hF000_0000 + 32'(k), 32'h100 + 32'(k));
    rd(A_FREE, v); check("R4 tx full", v, 32'h0000_0400);
    wr(A_TX, 32'hDEAD_0000);
    rd(A_STAT, v); check("R4 overflow bit", v, 32'h100);
    rd(A_FREE, v); check("R4 free unchanged", v, 32'h0000_0400);
    wr(A_TX, 32'hDEAD_0001);
    for (int k = 0; k < DEPTH; k++)
      serve("R4 queued kept", 1'b0, 32'hF000_0000 + 32'(k), 32'h100 + 32'(k), 4'h0, 0);
    rd(A_STAT, v); check("R4 overflow sticky", v, 32'h101);
    put_bd(A_TX, 32'hE000_0000, 32'h0000_00E1);
    serve("R4 no stale half word", 1'b0, 32'hE000_0000, 32'h0000_00E1, 4'h0, 0);

    // R5 independent half-descriptor latches
    put_bd(A_TX, 32'h5A00_0000, 32'h0);  // placeholder pair replaced below
    serve("R5 warmup", 1'b0, 32'h5A00_0000, 32'h0, 4'h0, 0);
    wr(A_TX, 32'h7100_0000);
    put_bd(A_RX, 32'h7200_0000, 32'h0000_0072);
    wr(A_TX, 32'h0000_0071);
    serve("R5 rx first", 1'b1, 32'h7200_0000, 32'h0000_0072, 4'h0, 0);
    serve("R5 tx intact", 1'b0, 32'h7100_0000, 32'h0000_0071, 4'h0, 0);

    // R11 stray done pulses
    wr(A_STAT, 32'h0);
    done_valid = 1'b1; done_err = 4'h3; @(negedge clk); done_valid = 1'b0; done_err = '0;
    rd(A_STAT, v); check("R11 idle done ignored", v, 32'h0);
    rd(A_FREE, v); check("R11 idle free unchanged", v, 32'h0000_0404);
    put_bd(A_RX, 32'h8800_0000, 32'h0000_0088);
    wait_valid("R11 pending");
    done_valid = 1'b1; done_err = 4'h2; @(negedge clk); done_valid = 1'b0; done_err = '0;
    rd(A_STAT, v); check("R11 done before ready ignored", v, 32'h0);
    rd(A_FREE, v); check("R11 slot still held", v, 32'h0000_0304);
    serve("R11 normal completion", 1'b1, 32'h8800_0000, 32'h0000_0088, 4'h0, 0);
    rd(A_STAT, v); check("R11 completion status", v, 32'h001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule